// File: doc/BRIEF.md
# Variable-Length Displacement Stream Decoder

This block pulls one signed displacement field out of an instruction byte stream. Bytes arrive one per cycle over a valid/ready handshake. The first byte of a field carries a length prefix in its top bits. A top bit of 0 means a one-byte field with a 7-bit payload. The pair 10 means a two-byte field with a 14-bit payload. The pair 11 means a four-byte field with a 30-bit payload.

Bytes come most significant first. The decoder removes the prefix and sign-extends the payload to a full word. It then presents the word for a single cycle, together with a done strobe and the field's length in bytes.

An operand may carry two displacements one after the other. For that reason the decoder is ready for the next field's leading byte on the cycle right after its done strobe. Operand specifiers, index bytes, address arithmetic and fetch buffering are handled by neighbouring blocks.

Top module: `disp_stream_decoder`

## Requirements
- R1: A leading byte whose bit 7 is 0 forms a complete one-byte field: its bits 6..0 are a signed value and `disp_len` reads 1.
- R2: A leading byte whose bits 7..6 are 10 starts a two-byte field: the 14-bit signed value is the leading byte's bits 5..0 followed by all 8 bits of the second byte, and `disp_len` reads 2.
- R3: A leading byte whose bits 7..6 are 11 starts a four-byte field: the 30-bit signed value is the leading byte's bits 5..0 followed by the next three bytes, and `disp_len` reads 4.
- R4: Within a field, the first byte accepted holds the most significant bits and each later byte holds the next less significant eight bits.
- R5: `disp_value` is the payload with the prefix removed and sign-extended to 32 bits, so the extremes are -64/+63, -8192/+8191 and -536870912/+536870911.
- R6: `disp_done` is high for exactly one cycle, the cycle after the clock edge that accepts a field's last byte; `disp_value` and `disp_len` are valid in that cycle.
- R7: `in_ready` is low in the done cycle and high in every other cycle outside reset; a byte is consumed only on an edge where `in_valid` and `in_ready` are both high.
- R8: The leading byte of the next field is accepted on the first edge after the done cycle, so two fields of different lengths decode back to back.
- R9: While `rst` is high on a clock edge, the decoder returns to idle and drops any partial field: afterwards `disp_done` is low, `in_ready` is high, and the next byte is taken as a leading byte.
- R10: Cycles in which `in_valid` is low inside a field neither advance nor disturb the field, and produce no done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte offered |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| disp_done | output | 1 | One-cycle strobe: a field is complete |
| disp_value | output | 32 | Sign-extended displacement, valid with `disp_done` (zero otherwise) |
| disp_len | output | 3 | Field length in bytes (1, 2 or 4), valid with `disp_done` (zero otherwise) |

## Verification
The one result per field is due in the cycle right after the edge that accepts the field's last byte. One cycle later `in_ready` is high again, so the next field's leading byte is due one edge after the strobe. The driver applies inputs on falling edges and checks `disp_done` and `in_ready` at the falling edge just after the last byte is taken. It also counts the wait for the next leading byte and expects exactly one. A monitor compares each strobe against a queue of values encoded in the bench, flags strobes lasting two cycles, and checks that gaps and mid-field resets give no strobe.

// File: rtl/dspd_pkg.sv
package dspd_pkg;

    localparam int unsigned BYTE_BITS       = 8;
    localparam int unsigned WORD_BITS       = 32;
    localparam int unsigned MAX_FIELD_BYTES = 4;
    localparam int unsigned NUM_FORMS       = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DONE    = 2'd2
    } dspd_state_e;

    // Form index f: 0 -> one byte, 1 -> two bytes, 2 -> four bytes
    function automatic int unsigned form_bytes(input int unsigned f);
        return 32'd1 << f;
    endfunction

    function automatic int unsigned form_prefix(input int unsigned f);
        return (f == 0) ? 1 : 2;
    endfunction

    function automatic int unsigned form_payload(input int unsigned f, input int unsigned bw);
        return form_bytes(f) * bw - form_prefix(f);
    endfunction

endpackage

// File: rtl/dspd_prefix.sv
module dspd_prefix #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input  logic [BYTE_W-1:0] lead,
    output logic [CNT_W-1:0]  lead_len
);
    always_comb begin
        if (!lead[BYTE_W-1])      lead_len = CNT_W'(1);
        else if (!lead[BYTE_W-2]) lead_len = CNT_W'(2);
        else                      lead_len = CNT_W'(4);
    end
endmodule

// File: rtl/dspd_ctrl.sv
module dspd_ctrl
    import dspd_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] lead_len,
    output logic             in_ready,
    output logic             take,
    output logic             first,
    output logic             done
);
    dspd_state_e      state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;

    assign in_ready = (state_q != ST_DONE);
    assign take     = in_valid & in_ready;
    assign first    = (state_q == ST_IDLE);
    assign done     = (state_q == ST_DONE);

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (lead_len == CNT_W'(1)) begin
                        state_d = ST_DONE;
                        rem_d   = '0;
                    end else begin
                        state_d = ST_COLLECT;
                        rem_d   = lead_len - CNT_W'(1);
                    end
                end
            end
            ST_COLLECT: begin
                if (take) begin
                    if (rem_q == CNT_W'(1)) begin
                        state_d = ST_DONE;
                        rem_d   = '0;
                    end else begin
                        rem_d = rem_q - CNT_W'(1);
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end
endmodule

// File: rtl/dspd_accum.sv
module dspd_accum #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OUT_W  = 32,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              first,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [CNT_W-1:0]  lead_len,
    output logic [OUT_W-1:0]  acc_q,
    output logic [CNT_W-1:0]  len_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            len_q <= '0;
        end else if (take) begin
            if (first) begin
                acc_q <= OUT_W'(in_byte);
                len_q <= lead_len;
            end else begin
                acc_q <= {acc_q[OUT_W-BYTE_W-1:0], in_byte};
            end
        end
    end
endmodule

// File: rtl/dspd_sext.sv
module dspd_sext
    import dspd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OUT_W  = 32,
    parameter int unsigned CNT_W  = 3
) (
    input  logic [OUT_W-1:0] acc,
    input  logic [CNT_W-1:0] len,
    output logic [OUT_W-1:0] value
);
    logic [OUT_W-1:0] ext [NUM_FORMS];

    for (genvar g = 0; g < NUM_FORMS; g++) begin : g_form
        localparam int unsigned PW = form_payload(g, BYTE_W);
        assign ext[g] = {{(OUT_W-PW){acc[PW-1]}}, acc[PW-1:0]};
    end

    always_comb begin
        unique case (len)
            CNT_W'(1): value = ext[0];
            CNT_W'(2): value = ext[1];
            default:   value = ext[2];
        endcase
    end
endmodule

// File: rtl/disp_stream_decoder.sv
module disp_stream_decoder
    import dspd_pkg::*;
#(
    parameter  int unsigned BYTE_W = BYTE_BITS,
    parameter  int unsigned OUT_W  = WORD_BITS,
    localparam int unsigned CNT_W  = $clog2(MAX_FIELD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              disp_done,
    output logic [OUT_W-1:0]  disp_value,
    output logic [CNT_W-1:0]  disp_len
);
    logic [CNT_W-1:0] lead_len;
    logic             take, first, done;
    logic [OUT_W-1:0] acc_q, ext_value;
    logic [CNT_W-1:0] len_q;

    dspd_prefix #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_prefix (
        .lead     (in_byte),
        .lead_len (lead_len)
    );

    dspd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .lead_len (lead_len),
        .in_ready (in_ready),
        .take     (take),
        .first    (first),
        .done     (done)
    );

    dspd_accum #(.BYTE_W(BYTE_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .first    (first),
        .in_byte  (in_byte),
        .lead_len (lead_len),
        .acc_q    (acc_q),
        .len_q    (len_q)
    );

    dspd_sext #(.BYTE_W(BYTE_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_sext (
        .acc   (acc_q),
        .len   (len_q),
        .value (ext_value)
    );

    assign disp_done  = done;
    assign disp_value = done ? ext_value : '0;
    assign disp_len   = done ? len_q : '0;
endmodule

// File: rtl/dspd_checker.sv
module dspd_checker #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OUT_W  = 32,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_byte,
    input logic              in_ready,
    input logic              disp_done,
    input logic [OUT_W-1:0]  disp_value,
    input logic [CNT_W-1:0]  disp_len
);
    localparam int unsigned SB1 = BYTE_W - 2;
    localparam int unsigned SB2 = 2 * BYTE_W - 3;
    localparam int unsigned SB4 = 4 * BYTE_W - 3;

    p_len_legal_r1: assert property (@(posedge clk) disable iff (rst)
        disp_done |-> (disp_len == CNT_W'(1) || disp_len == CNT_W'(2) || disp_len == CNT_W'(4)));

    p_sext_short_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_done && disp_len == CNT_W'(1)) |->
            ((&disp_value[OUT_W-1:SB1]) || (disp_value[OUT_W-1:SB1] == '0)));

    p_sext_mid_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_done && disp_len == CNT_W'(2)) |->
            ((&disp_value[OUT_W-1:SB2]) || (disp_value[OUT_W-1:SB2] == '0)));

    p_sext_long_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_done && disp_len == CNT_W'(4)) |->
            ((&disp_value[OUT_W-1:SB4]) || (disp_value[OUT_W-1:SB4] == '0)));

    p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        disp_done |=> !disp_done);

    p_done_after_take_r6: assert property (@(posedge clk) disable iff (rst)
        disp_done |-> $past(in_valid && in_ready));

    p_ready_low_done_r7: assert property (@(posedge clk) disable iff (rst)
        disp_done |-> !in_ready);

    p_ready_back_r8: assert property (@(posedge clk) disable iff (rst)
        disp_done |=> in_ready);

    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (!disp_done && in_ready));

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !disp_done) |=> !disp_done);
endmodule

bind disp_stream_decoder dspd_checker #(
    .BYTE_W (BYTE_W),
    .OUT_W  (OUT_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_ready   (in_ready),
    .disp_done  (disp_done),
    .disp_value (disp_value),
    .disp_len   (disp_len)
);

// File: tb/sim_disp_stream_decoder.sv
module sim_disp_stream_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        disp_done;
    logic [31:0] disp_value;
    logic [2:0]  disp_len;

    disp_stream_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .disp_done(disp_done),
        .disp_value(disp_value), .disp_len(disp_len)
    );

    always #5 clk = ~clk;

    typedef struct { int val; int nb; } exp_t;
    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   prev_done = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected results as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (disp_done) begin
                check(!prev_done, "R6", "strobe longer than one cycle", 2, 1);
                check(!in_ready, "R7", "ready during done", in_ready, 0);
                if (sb.size() == 0) begin
                    check(1'b0, "R6", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    string tag;
                    e = sb.pop_front();
                    tag = (e.nb == 1) ? "R1" : (e.nb == 2) ? "R2" : "R3";
                    check(disp_value == 32'(e.val), tag, "R5 value",
                          $signed(disp_value), e.val);
                    check(int'(disp_len) == e.nb, tag, "length", disp_len, e.nb);
                end
            end
        end
        prev_done = disp_done;
    end

    // Big-endian encoding with length prefix (R1..R4)
    function automatic void encode(input int v, input int n, output logic [7:0] b [4]);
        logic [15:0] h;
        logic [31:0] w;
        b[0] = 8'h00; b[1] = 8'h00; b[2] = 8'h00; b[3] = 8'h00;
        if (n == 1) begin
            b[0] = {1'b0, v[6:0]};
        end else if (n == 2) begin
            h = {2'b10, v[13:0]};
            b[0] = h[15:8]; b[1] = h[7:0];
        end else begin
            w = {2'b11, v[29:0]};
            b[0] = w[31:24]; b[1] = w[23:16]; b[2] = w[15:8]; b[3] = w[7:0];
        end
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance
    task automatic send_byte(input logic [7:0] b, output int waits);
        in_valid = 1'b1;
        in_byte  = b;
        waits    = 0;
        while (!in_ready) begin
            @(negedge clk);
            waits++;
        end
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        in_valid = 1'b0;
        in_byte  = 8'hC3;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!disp_done, "R10", "done during gap", disp_done, 0);
        end
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_field(input int v, input int n, input int gp, output int first_wait);
        logic [7:0] b [4];
        exp_t e;
        int w;
        encode(v, n, b);
        e.val = v; e.nb = n;
        sb.push_back(e);
        first_wait = 0;
        for (int i = 0; i < n; i++) begin
            send_byte(b[i], w);
            if (i == 0) first_wait = w;
            if (gp > 0 && i < n - 1) gap(gp);
        end
        check(disp_done === 1'b1, "R6", "done after last byte", disp_done, 1);
        check(in_ready === 1'b0, "R7", "ready in done cycle", in_ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!disp_done, "R9", "done in reset", disp_done, 0);
        check(in_ready, "R9", "ready in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready, "R7", "ready when idle", in_ready, 1);

        // One-byte form
        send_field(63, 1, 0, w);   idle(2);
        send_field(-64, 1, 0, w);  idle(2);
        send_field(0, 1, 0, w);    idle(2);
        send_field(-1, 1, 0, w);   idle(2);

        // Two-byte form, byte order R4
        send_field(8191, 2, 0, w);  idle(2);
        send_field(-8192, 2, 0, w); idle(2);
        send_field(32'h1234, 2, 0, w); idle(2);

        // Four-byte form, byte order R4
        send_field(536870911, 4, 0, w);  idle(2);
        send_field(-536870912, 4, 0, w); idle(2);
        send_field(32'h12345678, 4, 0, w); idle(2);
        send_field(-305419896, 4, 0, w); idle(2);

        // Back to back, mixed lengths (R8)
        send_field(-4000, 4, 0, w);
        check(w == 0, "R8", "wait before first field", w, 0);
        send_field(-3, 1, 0, w);
        check(w == 1, "R8", "wait after done", w, 1);
        send_field(341, 2, 0, w);
        check(w == 1, "R8", "wait after done", w, 1);
        send_field(-7, 4, 0, w);
        check(w == 1, "R8", "wait after done", w, 1);
        send_field(12, 1, 0, w);
        check(w == 1, "R8", "wait after done", w, 1);
        idle(2);

        // Gaps inside fields (R10)
        send_field(8191, 2, 3, w); idle(2);
        send_field(-123456, 4, 2, w); idle(2);

        // Reset mid-field drops the partial field (R9)
        send_byte(8'hC0, w);
        send_byte(8'h12, w);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!disp_done, "R9", "done after reset", disp_done, 0);
        check(in_ready, "R9", "ready after reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        send_field(5, 1, 0, w);
        idle(3);

        check(sb.size() == 0, "R6", "results still pending", sb.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule